// File: doc/BRIEF.md
# Register-Mapped Factorial Accelerator

This block computes the factorial of a 32-bit operand in the background and is driven through a small register port. Software writes the operand into the shared operand/result register. It then either polls the busy bit in the status register or waits for the completion request. When the work is finished, the result is read back from the same register. The product is kept to 32 bits, so any operand above 12 returns the low 32 bits of the true factorial.

The register port has no flow control. A write is taken in the clock cycle in which the write enable is high. Read data is a combinational function of the address. A write that would start a second computation while one is already running is dropped silently, so the port never back-pressures. The completion request is a one-cycle pulse, meant for an interrupt collector outside this block. It is only produced when the enable bit in the status register is set.

Top module: `fact_accel`

## Requirements
- R1: After reset the operand/result register (offset 0x08) reads 0, the status register (offset 0x20) reads 0 and irq_req is low.
- R2: A write to offset 0x08 while idle loads the written value. Reads of offset 0x08 return that operand until the result is stored, and status bit 0 (busy) reads 1 from the next cycle on.
- R3: The stored result equals N*(N-1)*...*1 modulo 2^32 for operand N. An operand of 0 gives 1.
- R4: For operand N, status bit 0 reads 1 for exactly N+1 consecutive cycles after the write edge. The result is readable in the first cycle in which the bit reads 0.
- R5: A write to offset 0x08 while busy has no effect: the result and the busy duration are those of the computation already running.
- R6: Status bit 7 is an interrupt enable. A write to offset 0x20 sets it to bit 7 of the written data, and reads of offset 0x20 return it in bit 7.
- R7: Writes to offset 0x20 never change status bit 0. Writing a 1 there while idle leaves it at 0.
- R8: When a result is stored with the enable set, irq_req is high for exactly one cycle, in the first cycle in which the result is readable. With the enable clear, no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr_en | input | 1 | Write strobe, taken at the rising edge |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data for reg_addr; unmapped offsets read 0 |
| irq_req | output | 1 | One-cycle completion request (cause bit 0) |

## Verification
A wrong step count in the sequencer shows up at once as a busy window of the wrong length, seen one cycle after the write. A wrong product shows up as a bad value on the first read after busy drops. If a dropped write were wrongly accepted, the result or the busy length would change. That case is checked by writing during a run and comparing both against the first operand. An enable bit that is held wrongly is exposed by status read-back right after the write, and by a pulse that is missing or unexpected in the cycle the result lands.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_OPRES  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h20;
  localparam int BIT_BUSY = 0;
  localparam int BIT_IEN  = 7;
endpackage

// File: rtl/fact_seq.sv
module fact_seq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] opres_q
);
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] prod_q;

  // Finishing step: counter has reached zero while running.
  assign done = busy && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      count_q <= '0;
      prod_q  <= '0;
      opres_q <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      count_q <= operand;
      prod_q  <= {{(DATA_W-1){1'b0}}, 1'b1};
      opres_q <= operand;
    end else if (done) begin
      busy    <= 1'b0;
      opres_q <= prod_q;
    end else if (busy) begin
      prod_q  <= prod_q * count_q;
      count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/fact_regs.sv
module fact_regs
  import fact_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] opres_q,
  output logic              start,
  output logic              irq_en,
  output logic              irq_req,
  output logic [DATA_W-1:0] reg_rd_data
);
  logic wr_opres, wr_status;

  assign wr_opres  = reg_wr_en && (reg_addr == OFS_OPRES);
  assign wr_status = reg_wr_en && (reg_addr == OFS_STATUS);
  assign start     = wr_opres && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en  <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      if (wr_status) irq_en <= reg_wr_data[BIT_IEN];
      irq_req <= done && irq_en;
    end
  end

  always_comb begin
    reg_rd_data = '0;
    case (reg_addr)
      OFS_OPRES: reg_rd_data = opres_q;
      OFS_STATUS: begin
        reg_rd_data[BIT_BUSY] = busy;
        reg_rd_data[BIT_IEN]  = irq_en;
      end
      default: reg_rd_data = '0;
    endcase
  end
endmodule

// File: rtl/fact_accel.sv
module fact_accel
  import fact_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              irq_req
);
  logic              seq_start, seq_busy, seq_done, irq_en;
  logic [DATA_W-1:0] opres_q;

  fact_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .operand(reg_wr_data),
    .busy(seq_busy), .done(seq_done), .opres_q(opres_q)
  );

  fact_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .busy(seq_busy), .done(seq_done),
    .opres_q(opres_q), .start(seq_start), .irq_en(irq_en),
    .irq_req(irq_req), .reg_rd_data(reg_rd_data)
  );
endmodule

// File: rtl/fact_accel_chk.sv
module fact_accel_chk
  import fact_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic              irq_req,
  input logic              busy,
  input logic              irq_en,
  input logic [DATA_W-1:0] opres_q
);
  logic wr_op, wr_st;
  assign wr_op = reg_wr_en && (reg_addr == OFS_OPRES);
  assign wr_st = reg_wr_en && (reg_addr == OFS_STATUS);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op && !busy) |=> busy);

  assert_drop_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op && busy) |=> (!busy || $stable(opres_q)));

  assert_ien_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st |=> (irq_en == $past(reg_wr_data[BIT_IEN])));

  assert_status_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && !busy) |=> !busy);

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  assert_irq_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($fell(busy) && $past(irq_en)));
endmodule

bind fact_accel fact_accel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
  .reg_wr_data(reg_wr_data), .irq_req(irq_req), .busy(seq_busy),
  .irq_en(irq_en), .opres_q(opres_q)
);

// File: tb/tb_fact_accel.sv
`timescale 1ns/1ps
module tb_fact_accel;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_OP = 8'h08;
  localparam logic [7:0] A_ST = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  logic [31:0] exp_q[$];

  fact_accel dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fact_model(logic [31:0] n);
    logic [31:0] p = 32'd1;
    for (logic [31:0] i = n; i > 0; i--) p = p * i;
    return p;
  endfunction

  // Monitor: on each completion pulse pop the expected result and compare.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && irq_req) begin
        irq_seen++;
        if (exp_q.size() == 0) check("R8 unexpected pulse", 32'd1, 32'd0);
        else check("R8 result at pulse", reg_rd_data, exp_q.pop_front());
      end
    end
  endtask_dummy: begin end
  end

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // Driver: start a run, measure busy length, check result, push to scoreboard.
  task automatic run_fact(logic [31:0] n, bit ien, bit poke);
    int cyc = 0;
    int irq_before = irq_seen;
    logic [31:0] expv = fact_model(n);
    if (ien) exp_q.push_back(expv);
    reg_write(A_OP, n);
    reg_addr = A_ST;
    #1;
    check("R2 operand readback", 32'(reg_rd_data[0]), 32'd1);
    forever begin
      if (!reg_rd_data[0]) break;
      cyc++;
      if (poke && cyc == 2) begin
        reg_addr = A_OP; reg_wr_en = 1'b1; reg_wr_data = 32'd3;
        #1;
        check("R2 operand held", reg_rd_data, n);
      end
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = A_ST;
      #1;
      if (cyc > 200) break;
    end
    check(poke ? "R5 busy length" : "R4 busy length", 32'(cyc), n + 1);
    reg_addr = A_OP;
    #1;
    check(poke ? "R5 result" : "R3 result", reg_rd_data, expv);
    repeat (3) @(negedge clk);
    check("R8 pulse count", 32'(irq_seen - irq_before), ien ? 32'd1 : 32'd0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_addr = A_OP; #1;
    check("R1 opres reset", reg_rd_data, 32'd0);
    reg_addr = A_ST; #1;
    check("R1 status reset", reg_rd_data, 32'd0);
    check("R1 irq reset", 32'(irq_req), 32'd0);

    reg_write(A_ST, 32'h0000_0081);
    reg_addr = A_ST; #1;
    check("R6 enable set / R7 busy untouched", reg_rd_data, 32'h80);
    reg_write(A_ST, 32'h0000_0001);
    reg_addr = A_ST; #1;
    check("R6 enable clear / R7 busy untouched", reg_rd_data, 32'h00);

    run_fact(32'd5, 1'b0, 1'b0);
    reg_write(A_ST, 32'h80);
    run_fact(32'd0, 1'b1, 1'b0);
    run_fact(32'd1, 1'b1, 1'b0);
    run_fact(32'd5, 1'b1, 1'b0);
    run_fact(32'd12, 1'b1, 1'b0);
    run_fact(32'd13, 1'b1, 1'b0);
    run_fact(32'd6, 1'b1, 1'b1);
    reg_write(A_ST, 32'h0);
    run_fact(32'd7, 1'b0, 1'b0);
    check("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule